// File: doc/BRIEF.md
# Key-Guarded Overflow Watchdog

This block is a memory-mapped watchdog built around a 16-bit up-counter. Software picks one of eight clock divide ratios, preloads the counter with 65536 minus the number of divided ticks it wants to allow, and sets the run bit. If the counter passes 0xFFFF before software reloads it, the block raises a sticky overflow flag and emits a single-cycle reset-request pulse.

Every register write must carry a key in the upper part of the data word. A write with a wrong key is dropped without any effect. An accepted write to the count or main control register holds a write-in-progress flag for two clock cycles. Software must clear the run bit before it changes the count or the divide ratio.

The bus is a plain single-cycle interface. A write is taken on the clock edge where select and write are both high. Read data is combinational from the word index.

Top module: `guarded_wdt`

## Requirements
- R1: After reset, the count reads 0, the main control register reads 0x00, the auxiliary register reads 0x00 and `resetReq` is low.
- R2: A write to word 0 whose bits 31:16 equal 0x5A5A loads bits 15:0 into the counter on that edge. Word 0 reads back the count in bits 15:0, with bits 31:16 zero.
- R3: A write to word 1 whose bits 31:8 equal 0xA5A5A5 is accepted. Word 1 reads as: bit 7 run enable, bit 5 write-in-progress (read only), bit 4 overflow flag, bits 2:0 divide select. Bits 6 and 3 always read 0, and so do bits 31:8.
- R4: A write whose key does not match its register changes no register and does not set the write-in-progress flag.
- R5: An accepted write to word 0 or word 1 makes the write-in-progress flag read 1 during the two cycles after the write edge and 0 from the third cycle on. Writes to word 2 never set it.
- R6: Divide select values 0..7 give one tick every 1, 4, 16, 32, 64, 128, 1024 and 4096 clocks. The first tick comes that many clocks after the enabling edge. While the run bit is 0 the count holds.
- R7: With the count loaded to 65536−T and the run bit set with divide ratio N on edge e, `resetReq` is high for exactly one cycle, following edge e+N·T. At that edge the count wraps to 0 and then keeps counting while the run bit stays set.
- R8: Overflow sets bit 4 of word 1, and the bit stays set. An accepted word 1 write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged. A new overflow wins over a clear on the same edge.
- R9: With the count at 0xFFFF, divide select 0 and the run bit set on edge e, `resetReq` is high in the cycle following edge e+1.
- R10: Word 2 is an 8-bit storage register. It is written from bits 7:0 when bits 31:8 equal 0xA5A5A5, it reads back in bits 7:0, and it affects nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe, taken with busSel on the rising edge |
| busWordAddr | input | 2 | Word index: 0 count, 1 main control, 2 auxiliary |
| busWdata | input | 32 | Write data including the key |
| busRdata | output | 32 | Combinational read data for busWordAddr |
| resetReq | output | 1 | One-cycle reset-request pulse on counter overflow |

## Verification
Register values and the write-in-progress flag change on the write edge itself, so the bench reads them back in the low half of the cycle that follows. It then samples the busy flag again one and two cycles later to pin the two-cycle window.

For timeouts, the bench counts falling edges from the enabling write. It expects the first `resetReq` sample at exactly N·T, and one pulse only. It then derives the count after wrap from how many further ticks fit before the disabling edge. All inputs are driven on falling edges, so no sample lands on an active edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 32;
  localparam int PRE_W   = 12;
  localparam int AUX_W   = 8;
  localparam int BUSY_W  = 2;
  localparam int BUSY_CYC = 2;
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CSR_KEY = 24'hA5A5A5;

  typedef struct packed {
    logic             loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic             runEn;
    logic [2:0]       divSel;
    logic             ovfClr;
  } ctrlStrobes_t;

  function automatic int unsigned divRatio(input logic [2:0] sel);
    case (sel)
      3'd0: divRatio = 1;
      3'd1: divRatio = 4;
      3'd2: divRatio = 16;
      3'd3: divRatio = 32;
      3'd4: divRatio = 64;
      3'd5: divRatio = 128;
      3'd6: divRatio = 1024;
      default: divRatio = 4096;
    endcase
  endfunction
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             resetReq
);
  logic [PRE_W-1:0] prescCnt;
  logic [PRE_W-1:0] terminal;
  logic             tick;
  logic             wrapNow;

  assign terminal = PRE_W'(divRatio(strb.divSel) - 1);
  assign tick     = strb.runEn && (prescCnt == terminal);
  assign wrapNow  = tick && (count == {CNT_W{1'b1}}) && !strb.loadCnt;

  // Prescaler: held at zero while stopped, restarts after each tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prescCnt <= '0;
    else if (!strb.runEn)  prescCnt <= '0;
    else if (tick)         prescCnt <= '0;
    else                   prescCnt <= prescCnt + 1'b1;
  end

  // Main counter: a load from the bus wins over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.loadCnt) count <= strb.loadVal;
    else if (tick)         count <= count + 1'b1;
  end

  // Overflow flag and request pulse; a new overflow wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= wrapNow;
      if (wrapNow)          ovfFlag <= 1'b1;
      else if (strb.ovfClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busWordAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfFlag,
  output ctrlStrobes_t      strb,
  output logic              busy,
  output logic [DATA_W-1:0] busRdata
);
  localparam logic [1:0] IDX_CNT = 2'd0;
  localparam logic [1:0] IDX_CSA = 2'd1;
  localparam logic [1:0] IDX_AUX = 2'd2;

  logic              wrOk;
  logic              cntKeyOk, csrKeyOk;
  logic              wrCnt, wrCsa, wrAux;
  logic              runEn;
  logic [2:0]        divSel;
  logic [AUX_W-1:0]  auxReg;
  logic [BUSY_W-1:0] busyCnt;

  assign wrOk     = busSel && busWrite;
  assign cntKeyOk = busWdata[DATA_W-1:CNT_W] == CNT_KEY;
  assign csrKeyOk = busWdata[DATA_W-1:8] == CSR_KEY;
  assign wrCnt    = wrOk && (busWordAddr == IDX_CNT) && cntKeyOk;
  assign wrCsa    = wrOk && (busWordAddr == IDX_CSA) && csrKeyOk;
  assign wrAux    = wrOk && (busWordAddr == IDX_AUX) && csrKeyOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn  <= 1'b0;
      divSel <= '0;
      auxReg <= '0;
    end else begin
      if (wrCsa) begin
        runEn  <= busWdata[7];
        divSel <= busWdata[2:0];
      end
      if (wrAux) auxReg <= busWdata[AUX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busyCnt <= '0;
    else if (wrCnt || wrCsa) busyCnt <= BUSY_W'(BUSY_CYC);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  assign busy = busyCnt != '0;

  always_comb begin
    strb.loadCnt = wrCnt;
    strb.loadVal = busWdata[CNT_W-1:0];
    strb.runEn   = runEn;
    strb.divSel  = divSel;
    strb.ovfClr  = wrCsa && !busWdata[4];
  end

  always_comb begin
    busRdata = '0;
    case (busWordAddr)
      IDX_CNT: busRdata[CNT_W-1:0] = count;
      IDX_CSA: busRdata[7:0] = {runEn, 1'b0, busy, ovfFlag, 1'b0, divSel};
      IDX_AUX: busRdata[AUX_W-1:0] = auxReg;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busWordAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              resetReq
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] countVal;
  logic             ovfFlag;
  logic             busyFlag;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .count(countVal),
    .ovfFlag(ovfFlag), .strb(strb), .busy(busyFlag), .busRdata(busRdata)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(countVal),
    .ovfFlag(ovfFlag), .resetReq(resetReq)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [1:0]        busWordAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              resetReq,
  input logic [CNT_W-1:0]  countVal,
  input logic              ovfFlag,
  input logic              busyFlag,
  input logic              runEn
);
  logic cntWrite, cntGood, csaGood;
  assign cntWrite = busSel && busWrite && busWordAddr == 2'd0;
  assign cntGood  = cntWrite && busWdata[31:16] == CNT_KEY;
  assign csaGood  = busSel && busWrite && busWordAddr == 2'd1 && busWdata[31:8] == CSR_KEY;

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ovfFlag);

  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntGood) |=> $stable(countVal));

  assert_bad_key_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrite && !cntGood && !runEn) |=> $stable(countVal));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> $past(cntGood || csaGood));

  assert_busy_two_cycles_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |=> busyFlag);
endmodule

bind guarded_wdt wdt_checker u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busWordAddr(busWordAddr), .busWdata(busWdata), .resetReq(resetReq),
  .countVal(countVal), .ovfFlag(ovfFlag), .busyFlag(busyFlag),
  .runEn(strb.runEn)
);

// File: tb/guarded_wdt_test.sv
module guarded_wdt_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [1:0]  busWordAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        resetReq;
  int          nTests = 0, nFail = 0;

  localparam logic [31:0] KC = 32'h5A5A_0000;
  localparam logic [31:0] KS = 32'hA5A5_A500;

  always #10 clk = ~clk;

  guarded_wdt uut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .resetReq(resetReq));

  function automatic int ratioOf(input int sel);
    case (sel)
      0: return 1;  1: return 4;  2: return 16;  3: return 32;
      4: return 64; 5: return 128; 6: return 1024; default: return 4096;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] idx, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busWordAddr = idx; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] idx, output logic [31:0] d);
    busWordAddr = idx;
    #1 d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic runTimeout(input int sel, input int ticks, input string req);
    logic [31:0] rd;
    int n, first, pulses, lim;
    n = ratioOf(sel);
    lim = n * ticks + 3;
    busWr(2'd1, KS);
    idle(2);
    busWr(2'd0, KC | 32'(65536 - ticks));
    idle(2);
    busWr(2'd1, KS | 32'h80 | 32'(sel));
    first = 0; pulses = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (resetReq) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
    check({req, " first request cycle"}, 32'(first), 32'(n * ticks));
    check({req, " request pulse count"}, 32'(pulses), 32'd1);
    busWr(2'd1, KS | 32'h10);          // stop, keep flag (R8: bit4=1 no clear)
    busRd(2'd0, rd);
    check("R7 count after wrap", rd, 32'(4 / n));
    busRd(2'd1, rd);
    check("R8 overflow flag sticky", rd & 32'h10, 32'h10);
    idle(2);
    busWr(2'd1, KS);                   // bit4=0 clears
    busRd(2'd1, rd);
    check("R8 overflow flag cleared", rd & 32'h10, 32'h0);
    idle(2);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    void'($urandom(32'h0BAD_5EED));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    busRd(2'd0, rd); check("R1 count", rd, 32'h0);
    busRd(2'd1, rd); check("R1 control", rd, 32'h0);
    busRd(2'd2, rd); check("R1 aux", rd, 32'h0);
    check("R1 resetReq", 32'(resetReq), 32'h0);

    // R2 count load, R5 busy window
    busWr(2'd0, KC | 32'h1234);
    busRd(2'd0, rd); check("R2 count load", rd, 32'h1234);
    busRd(2'd1, rd); check("R5 busy cycle 1", rd, 32'h20);
    @(negedge clk);
    busRd(2'd1, rd); check("R5 busy cycle 2", rd, 32'h20);
    @(negedge clk);
    busRd(2'd1, rd); check("R5 busy cleared", rd, 32'h0);

    // R4 wrong keys
    busWr(2'd0, 32'h5A5B_0000 | 32'h0077);
    busRd(2'd0, rd); check("R4 count unchanged", rd, 32'h1234);
    busRd(2'd1, rd); check("R4 no busy", rd, 32'h0);
    busWr(2'd1, 32'hA5A5_A400 | 32'h87);
    busRd(2'd1, rd); check("R4 control unchanged", rd, 32'h0);

    // R6 stopped counter holds
    idle(10);
    busRd(2'd0, rd); check("R6 hold while stopped", rd, 32'h1234);

    // R3 layout: write all ones, bit4=1 does not set flag
    busWr(2'd1, KS | 32'hFF);
    idle(2);
    busRd(2'd1, rd); check("R3 control readback", rd, 32'h87);
    busWr(2'd1, KS);
    idle(2);
    busRd(2'd1, rd); check("R3 disabled", rd, 32'h0);

    // R6 divide-by-1 rate
    busWr(2'd0, KC | 32'h0100);
    idle(2);
    busWr(2'd1, KS | 32'h80);
    idle(10);
    busRd(2'd0, rd); check("R6 ticks at divide 1", rd, 32'h010A);
    busWr(2'd1, KS);
    busRd(2'd0, rd); idle(5);
    busRd(2'd0, rd2); check("R6 stopped after disable", rd2, rd);
    idle(2);

    // R6 divide-by-4 rate: 12 cycles -> 3 ticks
    busWr(2'd0, KC | 32'h0200);
    idle(2);
    busWr(2'd1, KS | 32'h81);
    idle(12);
    busRd(2'd0, rd); check("R6 ticks at divide 4", rd, 32'h0203);
    busWr(2'd1, KS);
    idle(2);

    // R10 aux register
    busWr(2'd2, KS | 32'hC3);
    busRd(2'd2, rd); check("R10 aux write", rd, 32'hC3);
    busRd(2'd1, rd); check("R10 aux no busy", rd, 32'h0);
    busWr(2'd2, 32'h1234_5678);
    busRd(2'd2, rd); check("R10 aux bad key", rd, 32'hC3);

    // R9 fast reset, directed corners for R7
    runTimeout(0, 1, "R9");
    runTimeout(6, 1, "R7 divide 1024");
    runTimeout(7, 2, "R7 divide 4096");
    runTimeout(2, 3, "R7 divide 16");
    for (int k = 0; k < 6; k++)
      runTimeout($urandom_range(0, 5), $urandom_range(1, 6), "R7 random");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule